// File: doc/BRIEF.md
# Memory-Mapped Address Decoder

This block steers each access from a 32-bit processor bus to one of four targets in a sparse 32-bit address map. The targets are a program ROM of 64 KiB, a 1 MiB data RAM, a 1 MiB video frame store and a 256-byte device window at the top of the address space. In the same cycle as the access, it drives a one-hot target select and the offset of the address within its region. Read data comes back on the following cycle. The ROM contents are generated by a fixed function of the word index. The RAM is a small behavioural array that folds onto the whole region. The video frame store lies outside the block and is fed by the select, offset and write data.

Each region allows only some access directions. An access in a forbidden direction is dropped, and so is any access to an address outside every region. A dropped access asserts no select, returns zero data and pulses an error output. The device window decodes two registers. A byte write to the terminal register produces a one-cycle character strobe. A read of the keyboard register returns whether the keyboard buffer is empty.

Top module: `mmd_top`

## Requirements
- R1: An address in 0x00000000–0x0000FFFF is the ROM. A read there asserts select bit 0. On the next cycle it returns the ROM word for index offset[15:2], where word(i) = (i × 0x9E3779B1) XOR 0x0F0F1234, computed modulo 2^32.
- R2: A write to the ROM region asserts no select and pulses the error output on the next cycle. The ROM contents do not change.
- R3: An address in 0x00100000–0x001FFFFF is the RAM, selected on bit 1, and it supports reads and writes. The size code sets which byte lanes a write touches. Code 0 is a byte and touches lane addr[1:0], taking write data bits 7:0. Code 1 is a halfword and touches the lanes chosen by addr[1], taking bits 15:0. Code 2 is a full word. Reads return the whole aligned word on the next cycle.
- R4: The offset output equals the address minus the base of the region it falls in, and it is zero for unmapped addresses. The RAM word index is offset[2 +: log2(RAM_WORDS)], so offsets beyond the array alias back onto it.
- R5: An address in 0x01000000–0x010FFFFF is the video region, and it is write-only. A write there asserts select bit 2. A read asserts no select, returns zero and pulses the error output.
- R6: An access to an address in no region asserts no select, returns zero data and pulses the error output for one cycle.
- R7: At most one select bit is high at any time. All select bits are zero when neither strobe is active.
- R8: A write of size code 0 to 0xFFFFFF00 asserts select bit 3. On the next cycle it raises term_valid for exactly one cycle, with term_char equal to write data bits 7:0. A write of any other size to that address, or a byte write to another address in the window, leaves term_valid low and raises no error.
- R9: A read of 0xFFFFFF18 returns kbd_empty in bit 0 and zero in bits 31:1 on the next cycle. A read of any other address in the window returns zero without an error.
- R10: While reset is asserted, read data, the error output and term_valid are zero.
- R11: Read data is zero in every cycle that follows a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Write data, right-aligned for narrow writes |
| kbd_empty | input | 1 | High while the keyboard buffer holds nothing |
| cpu_rdata | output | 32 | Read data, valid one cycle after the read |
| tgt_sel | output | 4 | One-hot target select: ROM, RAM, video, devices |
| tgt_offset | output | 32 | Address relative to the selected region base |
| acc_err | output | 1 | One-cycle pulse after a dropped access |
| term_valid | output | 1 | Terminal character strobe |
| term_char | output | 8 | Terminal character |

## Verification
The bench builds the block with RAM_WORDS set to 16, so the RAM array covers only 64 bytes. This makes aliasing easy to reach. A read at RAM offset 0x40 lands on word 0. A write at the last address of the 1 MiB region folds onto word 15, where it can be read back through offset 0x3C. These cases cannot be reached with the default depth without long address sweeps.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  localparam int NREG = 4;

  // Target indices (bit positions in the select vector)
  localparam int T_ROM  = 0;
  localparam int T_RAM  = 1;
  localparam int T_VID  = 2;
  localparam int T_MMIO = 3;

  // Region match: (addr & mask) == base, index 0 at the right
  localparam logic [NREG-1:0][31:0] REG_BASE = {
    32'hFFFF_FF00, 32'h0100_0000, 32'h0010_0000, 32'h0000_0000 };
  localparam logic [NREG-1:0][31:0] REG_MASK = {
    32'hFFFF_FF00, 32'hFFF0_0000, 32'hFFF0_0000, 32'hFFFF_0000 };

  // Allowed directions per target
  localparam logic [NREG-1:0] REG_RD_OK = 4'b1011;
  localparam logic [NREG-1:0] REG_WR_OK = 4'b1110;

  // Access size codes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Device window register offsets
  localparam logic [7:0] TERM_OFF = 8'h00;
  localparam logic [7:0] KBD_OFF  = 8'h18;

  function automatic logic [31:0] rom_word(input logic [13:0] idx);
    return ({18'd0, idx} * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] a);
    case (size)
      SZ_BYTE: lane_mask = 4'b0001 << a;
      SZ_HALF: lane_mask = a[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] lane_data(input logic [1:0] size, input logic [31:0] d);
    case (size)
      SZ_BYTE: lane_data = {4{d[7:0]}};
      SZ_HALF: lane_data = {2{d[15:0]}};
      default: lane_data = d;
    endcase
  endfunction

endpackage

// File: rtl/mmd_decode.sv
module mmd_decode
  import mmd_pkg::*;
(
  input  logic [31:0]     addr,
  input  logic            rd,
  input  logic            wr,
  output logic [NREG-1:0] sel,
  output logic [31:0]     offset,
  output logic            dec_err
);

  logic [NREG-1:0] hit;
  logic [NREG-1:0] allow;
  logic [31:0]     part [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_region
      assign hit[g]   = (addr & REG_MASK[g]) == REG_BASE[g];
      assign allow[g] = (rd && REG_RD_OK[g]) || (wr && REG_WR_OK[g]);
      assign part[g]  = hit[g] ? (addr & ~REG_MASK[g]) : 32'd0;
    end
  endgenerate

  always_comb begin
    offset = 32'd0;
    for (int i = 0; i < NREG; i++) offset = offset | part[i];
    sel     = hit & allow;
    dec_err = (rd || wr) && (sel == '0);
  end

endmodule

// File: rtl/mmd_ram.sv
module mmd_ram #(
  parameter  int WORDS = 256,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [3:0]    wmask,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] idx,
  output logic [31:0]   rdata
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 4; b++) begin
        if (wmask[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 32'd0;
    else if (re) rdata <= mem[idx];
  end

endmodule

// File: rtl/mmd_mmio.sv
module mmd_mmio
  import mmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        rd,
  input  logic        wr,
  input  logic [1:0]  size,
  input  logic [7:0]  off,
  input  logic [7:0]  wbyte,
  input  logic        kbd_empty,
  output logic        term_valid,
  output logic [7:0]  term_char,
  output logic [31:0] rdata
);

  logic term_hit;
  logic kbd_hit;

  assign term_hit = sel && wr && (off == TERM_OFF) && (size == SZ_BYTE);
  assign kbd_hit  = sel && rd && (off == KBD_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_valid <= 1'b0;
      term_char  <= 8'd0;
      rdata      <= 32'd0;
    end else begin
      term_valid <= term_hit;
      if (term_hit) term_char <= wbyte;
      rdata <= kbd_hit ? {31'd0, kbd_empty} : 32'd0;
    end
  end

endmodule

// File: rtl/mmd_top.sv
module mmd_top
  import mmd_pkg::*;
#(
  parameter  int RAM_WORDS = 256,
  localparam int RAM_AW    = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_wdata,
  input  logic        kbd_empty,
  output logic [31:0] cpu_rdata,
  output logic [3:0]  tgt_sel,
  output logic [31:0] tgt_offset,
  output logic        acc_err,
  output logic        term_valid,
  output logic [7:0]  term_char
);

  // Named internal events
  logic        dec_err;
  logic        ram_we;
  logic        ram_re;
  logic [31:0] ram_q;
  logic [31:0] mmio_q;
  logic [31:0] rom_q;
  logic        rd_rom_q, rd_ram_q, rd_mmio_q;

  mmd_decode u_dec (
    .addr    (cpu_addr),
    .rd      (cpu_rd),
    .wr      (cpu_wr),
    .sel     (tgt_sel),
    .offset  (tgt_offset),
    .dec_err (dec_err)
  );

  assign ram_we = tgt_sel[T_RAM] && cpu_wr;
  assign ram_re = tgt_sel[T_RAM] && cpu_rd;

  mmd_ram #(.WORDS(RAM_WORDS)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .wmask (lane_mask(cpu_size, cpu_addr[1:0])),
    .wdata (lane_data(cpu_size, cpu_wdata)),
    .re    (ram_re),
    .idx   (tgt_offset[2 +: RAM_AW]),
    .rdata (ram_q)
  );

  mmd_mmio u_mmio (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (tgt_sel[T_MMIO]),
    .rd         (cpu_rd),
    .wr         (cpu_wr),
    .size       (cpu_size),
    .off        (tgt_offset[7:0]),
    .wbyte      (cpu_wdata[7:0]),
    .kbd_empty  (kbd_empty),
    .term_valid (term_valid),
    .term_char  (term_char),
    .rdata      (mmio_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_q     <= 32'd0;
      rd_rom_q  <= 1'b0;
      rd_ram_q  <= 1'b0;
      rd_mmio_q <= 1'b0;
      acc_err   <= 1'b0;
    end else begin
      rom_q     <= rom_word(tgt_offset[15:2]);
      rd_rom_q  <= tgt_sel[T_ROM]  && cpu_rd;
      rd_ram_q  <= tgt_sel[T_RAM]  && cpu_rd;
      rd_mmio_q <= tgt_sel[T_MMIO] && cpu_rd;
      acc_err   <= dec_err;
    end
  end

  always_comb begin
    cpu_rdata = 32'd0;
    if (rd_rom_q)  cpu_rdata = cpu_rdata | rom_q;
    if (rd_ram_q)  cpu_rdata = cpu_rdata | ram_q;
    if (rd_mmio_q) cpu_rdata = cpu_rdata | mmio_q;
  end

endmodule

// File: rtl/mmd_checker.sv
module mmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [1:0]  cpu_size,
  input logic [7:0]  wdata_lo,
  input logic [31:0] cpu_rdata,
  input logic [3:0]  tgt_sel,
  input logic        acc_err,
  input logic        term_valid,
  input logic [7:0]  term_char,
  input logic        dec_err
);

  a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  a_r7_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> tgt_sel == 4'b0000);

  a_r6_err_follows_decode: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> acc_err);

  a_r6_no_spurious_err: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_err |=> !acc_err);

  a_r2_rom_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[31:16] == 16'h0000) |=> acc_err);

  a_r5_video_read_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[31:20] == 12'h010) |=> (acc_err && cpu_rdata == 32'd0));

  a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> cpu_rdata == 32'd0);

  a_r8_term_source: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> ($past(cpu_wr) && $past(cpu_addr) == 32'hFFFF_FF00 &&
                    $past(cpu_size) == 2'd0 && term_char == $past(wdata_lo)));

endmodule

bind mmd_top mmd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .cpu_size   (cpu_size),
  .wdata_lo   (cpu_wdata[7:0]),
  .cpu_rdata  (cpu_rdata),
  .tgt_sel    (tgt_sel),
  .acc_err    (acc_err),
  .term_valid (term_valid),
  .term_char  (term_char),
  .dec_err    (dec_err)
);

// File: tb/mmd_top_tb.sv
`timescale 1ns/1ps
module mmd_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = 32'd0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_size = 2'd2;
  logic [31:0] cpu_wdata = 32'd0;
  logic        kbd_empty = 1'b1;
  logic [31:0] cpu_rdata;
  logic [3:0]  tgt_sel;
  logic [31:0] tgt_offset;
  logic        acc_err;
  logic        term_valid;
  logic [7:0]  term_char;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  mmd_top #(.RAM_WORDS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .kbd_empty(kbd_empty), .cpu_rdata(cpu_rdata), .tgt_sel(tgt_sel),
    .tgt_offset(tgt_offset), .acc_err(acc_err), .term_valid(term_valid),
    .term_char(term_char)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        rd;
    logic        wr;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  sel;
    logic [31:0] off;
    logic        err;
    logic        romx;   // expected read data is the ROM word for off
    logic [31:0] rdata;
    logic        tv;
    logic [7:0]  tc;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    // R1 ROM reads
    '{4'd1, 1'b1, 1'b0, 2'd2, 32'h0000_0000, 32'h0, 4'b0001, 32'h0000_0000, 1'b0, 1'b1, 32'h0, 1'b0, 8'h00},
    '{4'd1, 1'b1, 1'b0, 2'd2, 32'h0000_FFFC, 32'h0, 4'b0001, 32'h0000_FFFC, 1'b0, 1'b1, 32'h0, 1'b0, 8'h00},
    // R2 ROM write dropped, contents unchanged
    '{4'd2, 1'b0, 1'b1, 2'd2, 32'h0000_0010, 32'hDEAD_BEEF, 4'b0000, 32'h0000_0010, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd2, 1'b1, 1'b0, 2'd2, 32'h0000_0010, 32'h0, 4'b0001, 32'h0000_0010, 1'b0, 1'b1, 32'h0, 1'b0, 8'h00},
    // R3 RAM word, byte and halfword lanes
    '{4'd3, 1'b0, 1'b1, 2'd2, 32'h0010_0000, 32'h1122_3344, 4'b0010, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd3, 1'b1, 1'b0, 2'd2, 32'h0010_0000, 32'h0, 4'b0010, 32'h0, 1'b0, 1'b0, 32'h1122_3344, 1'b0, 8'h00},
    '{4'd3, 1'b0, 1'b1, 2'd0, 32'h0010_0001, 32'h0000_00AB, 4'b0010, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd3, 1'b1, 1'b0, 2'd2, 32'h0010_0000, 32'h0, 4'b0010, 32'h0, 1'b0, 1'b0, 32'h1122_AB44, 1'b0, 8'h00},
    '{4'd3, 1'b0, 1'b1, 2'd1, 32'h0010_0002, 32'h0000_BEEF, 4'b0010, 32'h2, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd3, 1'b1, 1'b0, 2'd2, 32'h0010_0000, 32'h0, 4'b0010, 32'h0, 1'b0, 1'b0, 32'hBEEF_AB44, 1'b0, 8'h00},
    // R4 offsets and aliasing with a 16-word array
    '{4'd4, 1'b1, 1'b0, 2'd2, 32'h0010_0040, 32'h0, 4'b0010, 32'h40, 1'b0, 1'b0, 32'hBEEF_AB44, 1'b0, 8'h00},
    '{4'd4, 1'b0, 1'b1, 2'd2, 32'h001F_FFFC, 32'hCAFE_F00D, 4'b0010, 32'h000F_FFFC, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd4, 1'b1, 1'b0, 2'd2, 32'h0010_003C, 32'h0, 4'b0010, 32'h3C, 1'b0, 1'b0, 32'hCAFE_F00D, 1'b0, 8'h00},
    // R5 video region write-only
    '{4'd5, 1'b0, 1'b1, 2'd2, 32'h0100_0000, 32'h1234_5678, 4'b0100, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd5, 1'b0, 1'b1, 2'd2, 32'h010F_FFF0, 32'h1234_5678, 4'b0100, 32'h000F_FFF0, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd5, 1'b1, 1'b0, 2'd2, 32'h0100_0004, 32'h0, 4'b0000, 32'h4, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00},
    // R6 unmapped gaps
    '{4'd6, 1'b1, 1'b0, 2'd2, 32'h0001_0000, 32'h0, 4'b0000, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd6, 1'b0, 1'b1, 2'd2, 32'h0020_0000, 32'h5555_AAAA, 4'b0000, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd6, 1'b1, 1'b0, 2'd2, 32'hFFFF_FEFC, 32'h0, 4'b0000, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd6, 1'b1, 1'b0, 2'd2, 32'h0110_0000, 32'h0, 4'b0000, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00},
    // R9 keyboard status and other window reads
    '{4'd9, 1'b1, 1'b0, 2'd0, 32'hFFFF_FF18, 32'h0, 4'b1000, 32'h18, 1'b0, 1'b0, 32'h1, 1'b0, 8'h00},
    '{4'd9, 1'b1, 1'b0, 2'd2, 32'hFFFF_FF04, 32'h0, 4'b1000, 32'h4, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00},
    // R8 terminal strobe
    '{4'd8, 1'b0, 1'b1, 2'd0, 32'hFFFF_FF00, 32'h0000_0041, 4'b1000, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, 8'h41},
    '{4'd8, 1'b0, 1'b1, 2'd2, 32'hFFFF_FF00, 32'h0000_0042, 4'b1000, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00},
    '{4'd8, 1'b0, 1'b1, 2'd0, 32'hFFFF_FF01, 32'h0000_0043, 4'b1000, 32'h1, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00}
  };

  // ROM word restated from R1: index = offset / 4
  function automatic logic [31:0] rom_ref(input logic [31:0] off);
    logic [31:0] i;
    i = off >> 2;
    return (i * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_size = 2'd2;
    cpu_addr = 32'd0; cpu_wdata = 32'd0;
  endtask

  task automatic run_vec(input vec_t v);
    string r;
    r = $sformatf("R%0d", v.req);
    @(negedge clk);
    cpu_rd = v.rd; cpu_wr = v.wr; cpu_size = v.size;
    cpu_addr = v.addr; cpu_wdata = v.wdata;
    #1;
    chk(r, "select", {28'd0, tgt_sel}, {28'd0, v.sel});
    chk(r, "offset", tgt_offset, v.off);
    @(negedge clk);
    chk(r, "error", {31'd0, acc_err}, {31'd0, v.err});
    chk(r, "rdata", cpu_rdata, v.romx ? rom_ref(v.off) : v.rdata);
    chk(r, "term_valid", {31'd0, term_valid}, {31'd0, v.tv});
    if (v.tv) chk(r, "term_char", {24'd0, term_char}, {24'd0, v.tc});
    drive_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10", "rdata in reset", cpu_rdata, 32'd0);
    chk("R10", "error in reset", {31'd0, acc_err}, 32'd0);
    chk("R10", "term_valid in reset", {31'd0, term_valid}, 32'd0);
    chk("R10", "select in reset", {28'd0, tgt_sel}, 32'd0);
    rst_n = 1'b1;

    // R7 no select without a strobe, even on a mapped address
    @(negedge clk);
    cpu_addr = 32'h0010_0000;
    #1;
    chk("R7", "idle select", {28'd0, tgt_sel}, 32'd0);
    drive_idle();

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8 strobe lasts a single cycle
    @(negedge clk);
    cpu_wr = 1'b1; cpu_size = 2'd0; cpu_addr = 32'hFFFF_FF00; cpu_wdata = 32'h0000_005A;
    @(negedge clk);
    drive_idle();
    chk("R8", "term_valid pulse", {31'd0, term_valid}, 32'd1);
    chk("R8", "term_char", {24'd0, term_char}, 32'h5A);
    @(negedge clk);
    chk("R8", "term_valid drop", {31'd0, term_valid}, 32'd0);

    // R9 keyboard not empty
    kbd_empty = 1'b0;
    @(negedge clk);
    cpu_rd = 1'b1; cpu_size = 2'd0; cpu_addr = 32'hFFFF_FF18;
    @(negedge clk);
    drive_idle();
    chk("R9", "kbd status not empty", cpu_rdata, 32'd0);

    // R11 read data clears after an idle cycle
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 32'h0000_0008;
    @(negedge clk);
    drive_idle();
    chk("R1", "rom word 2", cpu_rdata, rom_ref(32'h8));
    @(negedge clk);
    chk("R11", "rdata after idle", cpu_rdata, 32'd0);

    // R6 error is a single-cycle pulse
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = 32'h8000_0000;
    @(negedge clk);
    drive_idle();
    chk("R6", "error pulse", {31'd0, acc_err}, 32'd1);
    @(negedge clk);
    chk("R6", "error drop", {31'd0, acc_err}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule